// File: doc/BRIEF.md
# Memory Wait Interrupt Status Unit

This unit holds the interrupt status for an asynchronous external-memory controller. It has three event sources:
- a rising edge on the external wait input, after a two-flop synchronizer;
- a line-trap strobe from the access logic, raised for an illegal access type or a bad cache line size;
- a timeout counter that times how long the wait input stays active during an extended access.

Each source sets its own sticky bit in a raw status word. The bits are set whatever the mask holds, and software clears a bit by writing 1 to it.

A mask register has two write addresses: one sets mask bits and one clears them. Reading either address returns the mask. A read-only masked view is the raw word ANDed with the mask. A single interrupt output is the OR of the masked bits.

Software reaches the unit through a simple register port. A write takes effect at the clock edge where `reg_sel` and `reg_wr` are both high. A read is combinational from `reg_addr`.

Top module: `mwait_irq_status`

## Requirements
- R1: After reset, the raw word and the mask are 0 and `irq` is low.
- R2: The address map is as follows. Address 0 is the raw word, with timeout at bit 0, line trap at bit 1 and wait rise at bit 2. Address 1 is the masked view. Address 2 sets mask bits. Address 3 clears mask bits. In every read, bits above bit 2 are 0.
- R3: Writing 1 to a raw bit clears it. Writing 0 to a raw bit leaves it unchanged.
- R4: A one-cycle pulse on `trap_evt` sets raw bit 1 at the next clock edge.
- R5: A 0-to-1 change on `wait_in` sets raw bit 2 on the third clock edge after the change, counted from the edge that first samples the new level. Holding `wait_in` at 1 does not set the bit again.
- R6: `acc_start` loads `max_wait` = M into the timeout counter. `acc_active` must stay high for the whole access. Suppose `wait_in` is high across exactly K clock edges. Raw bit 0 is then set if K ≥ M+1, and stays clear if K ≤ M.
- R7: No timeout is flagged once `acc_active` falls, nor after the synchronized wait falls.
- R8: The timeout flag is raised at most once per access. After software clears it, the flag stays clear for the rest of that access.
- R9: Writing 1s to address 2 sets the matching mask bits. Writing 1s to address 3 clears them. Zero bits in either write leave the mask unchanged. Both addresses read the current mask.
- R10: The masked view equals raw AND mask, so clearing a raw bit also clears its masked bit. Raw bits are set even when their mask bit is 0.
- R11: `irq` is high exactly when some masked bit is 1.
- R12: If a hardware set and a software clear hit the same raw bit in the same cycle, the bit ends up 1.
- R13: Writes to address 1 change neither the raw word nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_in | input | 1 | External wait input, asynchronous, active high |
| acc_start | input | 1 | One-cycle pulse at the start of an extended access |
| acc_active | input | 1 | High while the extended access is in progress |
| trap_evt | input | 1 | Line-trap event strobe |
| max_wait | input | CNT_W | Timeout limit in counted cycles |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions make three assumptions about the inputs. `trap_evt` is a clean synchronous pulse. `acc_start` never comes in the same cycle as a register write. Writes are single-cycle strobes whose address is stable at the clock edge. The bench keeps to these assumptions: it drives every input at the falling edge, holds each strobe for exactly one cycle, and pulses `acc_start` before it raises `wait_in`. It also drives `acc_active` low whenever no access is under test. The exact timeout boundary depends on the two-cycle synchronizer delay, so the bench counts the clock edges over which it holds `wait_in` high.

// File: rtl/mwait_irq_status.sv
module mwait_irq_status #(
  parameter int DW    = 32,
  parameter int CNT_W = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_in,
  input  logic             acc_start,
  input  logic             acc_active,
  input  logic             trap_evt,
  input  logic [CNT_W-1:0] max_wait,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  localparam int NSRC = 3;
  localparam logic [AW-1:0] A_RAW  = AW'(0);
  localparam logic [AW-1:0] A_MSKD = AW'(1);
  localparam logic [AW-1:0] A_MSET = AW'(2);
  localparam logic [AW-1:0] A_MCLR = AW'(3);

  logic            w_s1, w_s2, w_d;
  logic            rise, to_hit;
  logic            armed, seen;
  logic [CNT_W-1:0] cnt;
  logic [NSRC-1:0] raw_q, mask_q, masked, set_v, clr_v;
  logic            wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {w_s1, w_s2, w_d} <= '0;
    else        {w_s1, w_s2, w_d} <= {wait_in, w_s1, w_s2};

  assign rise = w_s2 & ~w_d;

  assign to_hit = armed & acc_active & w_s2 & (cnt == '0) & ~acc_start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      seen  <= 1'b0;
      cnt   <= '0;
    end else if (acc_start) begin
      armed <= 1'b1;
      seen  <= 1'b0;
      cnt   <= max_wait;
    end else if (armed) begin
      if (!acc_active || (seen && !w_s2)) armed <= 1'b0;
      else if (w_s2) begin
        seen <= 1'b1;
        if (cnt == '0) armed <= 1'b0;
        else           cnt   <= cnt - 1'b1;
      end
    end

  assign wr    = reg_sel & reg_wr;
  assign set_v = {rise, trap_evt, to_hit};
  assign clr_v = (wr && reg_addr == A_RAW) ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else if (wr && reg_addr == A_MSET) mask_q <= mask_q | reg_wdata[NSRC-1:0];
    else if (wr && reg_addr == A_MCLR) mask_q <= mask_q & ~reg_wdata[NSRC-1:0];

  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_RAW:   reg_rdata[NSRC-1:0] = raw_q;
      A_MSKD:  reg_rdata[NSRC-1:0] = masked;
      default: reg_rdata[NSRC-1:0] = mask_q;
    endcase
  end
endmodule

// File: rtl/mwait_irq_status_chk.sv
module mwait_irq_status_chk #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          trap_evt,
  input logic          acc_start,
  input logic          rise,
  input logic          to_hit,
  input logic [2:0]    raw_q,
  input logic [2:0]    mask_q,
  input logic          irq
);
  logic wr_raw, wr_set, wr_clr;
  assign wr_raw = reg_sel && reg_wr && reg_addr == AW'(0);
  assign wr_set = reg_sel && reg_wr && reg_addr == AW'(2);
  assign wr_clr = reg_sel && reg_wr && reg_addr == AW'(3);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (raw_q == '0 && mask_q == '0));

  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_raw |=> ((($past(raw_q) & ~$past(reg_wdata[2:0])) & ~raw_q) == 3'b000));

  a_r3_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_raw && reg_wdata[1] && !trap_evt) |=> !raw_q[1]);

  a_r4_trap_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q[1]) |-> $past(trap_evt));

  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  a_r8_timeout_once: assert property (@(posedge clk) disable iff (!rst_n)
    (to_hit && !acc_start) |=> !to_hit);

  a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask_q & $past(reg_wdata[2:0])) == $past(reg_wdata[2:0])));

  a_r9_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask_q & $past(reg_wdata[2:0])) == 3'b000));

  a_r11_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q == 3'b000 || mask_q == 3'b000) |-> !irq);

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> raw_q[1]);
endmodule

bind mwait_irq_status mwait_irq_status_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .trap_evt(trap_evt),
  .acc_start(acc_start), .rise(rise), .to_hit(to_hit),
  .raw_q(raw_q), .mask_q(mask_q), .irq(irq));

// File: tb/mwait_irq_status_bench.sv
module mwait_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wait_in = 1'b0, acc_start = 1'b0, acc_active = 1'b0, trap_evt = 1'b0;
  logic [7:0]  max_wait = 8'd4;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mwait_irq_status u_mwait_irq_status (
    .clk(clk), .rst_n(rst_n), .wait_in(wait_in), .acc_start(acc_start),
    .acc_active(acc_active), .trap_evt(trap_evt), .max_wait(max_wait),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
  endtask

  task automatic hold_wait(input int edges);
    wait_in = 1'b1;
    repeat (edges) @(negedge clk);
    wait_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic start_access(input logic [7:0] m);
    max_wait = m; acc_active = 1'b1; acc_start = 1'b1;
    @(negedge clk);
    acc_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 raw after reset", d, 0);
    rd(2'd2, d); check("R1 mask after reset", d, 0);
    check("R1 irq after reset", {31'd0, irq}, 0);
  endtask

  task automatic t_trap();
    logic [31:0] d;
    trap_evt = 1'b1; @(negedge clk); trap_evt = 1'b0;
    rd(2'd0, d); check("R4 R2 trap sets bit1 only", d, 32'h2);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R3 write 0 keeps bit", d, 32'h2);
    wr(2'd0, 32'h2);
    rd(2'd0, d); check("R3 write 1 clears bit", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wait_in = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd0, d); check("R5 no flag before sync", d, 0);
    @(negedge clk);
    rd(2'd0, d); check("R5 R2 rise sets bit2", d, 32'h4);
    wr(2'd0, 32'h4);
    repeat (4) @(negedge clk);
    rd(2'd0, d); check("R5 held level no re-set", d, 0);
    wait_in = 1'b0; repeat (4) @(negedge clk);
    clear_all();
  endtask

  task automatic t_timeout_boundary();
    logic [31:0] d;
    start_access(8'd4); hold_wait(4); acc_active = 1'b0;
    rd(2'd0, d); check("R6 K=M no timeout", d & 32'h1, 0);
    clear_all();
    start_access(8'd4); hold_wait(5); acc_active = 1'b0;
    rd(2'd0, d); check("R6 K=M+1 timeout", d & 32'h1, 1);
    clear_all();
  endtask

  task automatic t_timeout_stop();
    logic [31:0] d;
    start_access(8'd3);
    wait_in = 1'b1; repeat (3) @(negedge clk);
    acc_active = 1'b0; repeat (8) @(negedge clk);
    wait_in = 1'b0; repeat (4) @(negedge clk);
    rd(2'd0, d); check("R7 access end stops timer", d & 32'h1, 0);
    clear_all();
  endtask

  task automatic t_timeout_once();
    logic [31:0] d;
    start_access(8'd2);
    wait_in = 1'b1; repeat (10) @(negedge clk);
    rd(2'd0, d); check("R6 long wait times out", d & 32'h1, 1);
    wr(2'd0, 32'h1);
    repeat (10) @(negedge clk);
    rd(2'd0, d); check("R8 timeout once per access", d & 32'h1, 0);
    wait_in = 1'b0; acc_active = 1'b0; repeat (4) @(negedge clk);
    clear_all();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(2'd2, 32'h5);
    rd(2'd2, d); check("R9 mask via set addr", d, 32'h5);
    rd(2'd3, d); check("R9 mask via clear addr", d, 32'h5);
    wr(2'd3, 32'h1);
    rd(2'd2, d); check("R9 clear bit0 only", d, 32'h4);
    trap_evt = 1'b1; @(negedge clk); trap_evt = 1'b0;
    rd(2'd0, d); check("R10 raw set while masked off", d, 32'h2);
    rd(2'd1, d); check("R10 masked view hides bit1", d, 0);
    check("R11 irq low when masked off", {31'd0, irq}, 0);
    wr(2'd2, 32'h2);
    rd(2'd1, d); check("R10 masked view bit1", d, 32'h2);
    check("R11 irq high", {31'd0, irq}, 1);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R13 masked write ignored raw", d, 32'h2);
    rd(2'd2, d); check("R13 masked write ignored mask", d, 32'h6);
    wr(2'd0, 32'h2);
    rd(2'd1, d); check("R10 raw clear clears masked", d, 0);
    check("R11 irq drops", {31'd0, irq}, 0);
    clear_all();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    trap_evt = 1'b1;
    wr(2'd0, 32'h2);
    trap_evt = 1'b0;
    rd(2'd0, d); check("R12 set beats clear", d, 32'h2);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trap();
    t_rise();
    t_timeout_boundary();
    t_timeout_stop();
    t_timeout_once();
    t_mask();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule